// File: doc/BRIEF.md
# Interrupt Line Dispatch Tracker

This block holds the dispatch state of a single interrupt line that any of several handler agents may pick up. Three flags describe the line: an event is waiting (pending), an agent owns the line and is running handlers (busy), and software has turned the line off (disabled). Each time an agent sees the line fire, the block masks the line, acknowledges the arrival and decides in the same cycle whether that agent takes ownership or only leaves a pending mark for the agent that already owns it.

The owning agent asks for handler time through a request/grant pair and reports the end of each pass with a done strobe tagged with its ID. After each pass the block checks the pending mark. If it is set, the mark is consumed and another pass is requested. If it is clear, ownership is dropped and the line is unmasked, unless the line was turned off in the meantime. An event recorded while the line was off is picked up when the line is turned back on.

The controller is a three-state machine. **IDLE** means no owner. **ASK** means the owner is requesting handler time. **SERVE** means a handler pass is running. The transitions are:
- *commit*: IDLE→ASK, on an arrival while the line is on, or on re-enable with an event waiting.
- *grant*: ASK→SERVE.
- *again*: SERVE→ASK, on the owner's done with an event pending.
- *finish*: SERVE→IDLE, on the owner's done with nothing pending.

Top module: `irq_line_tracker`

## Requirements
- R1: After reset the line is unmasked, no flag is set, no run request is raised and the acknowledge vector is zero.
- R2: An arrival from agent i (bit i of `arr_valid`) raises bit i of `ack_out` for exactly the following cycle and leaves `line_mask` at 1 from the following cycle.
- R3: An arrival while the line is idle and enabled commits the agent on the next cycle: `busy_flag`=1, `pend_flag`=0, `run_owner` is the agent's index, and `run_req`=1.
- R4: When several agents arrive together on an idle, enabled line, the lowest index wins ownership and `pend_flag` stays 0; the other arrivals are folded into the committed pass.
- R5: An arrival while the line is busy sets `pend_flag` and leaves `run_owner` unchanged.
- R6: `run_grant` while `run_req` is high drops `run_req` on the next cycle; the line stays busy.
- R7: A done from the owner during a pass, with an event pending, clears `pend_flag` and raises `run_req` again for another pass.
- R8: A done from the owner with nothing pending clears `busy_flag` and `run_req`, and unmasks the line if it is not disabled.
- R9: A done strobe whose `done_agent` differs from `run_owner`, or one that arrives outside a pass, has no effect.
- R10: A line disabled during a pass stays masked after the final done, and `dis_flag` implies `line_mask` at all times.
- R11: An arrival while the line is disabled and idle sets `pend_flag` only; no agent commits.
- R12: Re-enabling an idle, disabled line with an event pending commits `en_agent` as owner and clears `pend_flag`. Without an event pending, re-enabling unmasks the line.
- R13: A disable and an enable request in the same cycle leave the line disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | N_AGENTS | One strobe per agent: the line fired on that agent |
| ack_out | output | N_AGENTS | Per-agent acknowledge, one cycle after the arrival |
| done_valid | input | 1 | Handler pass finished |
| done_agent | input | AGENT_W | Agent reporting the finished pass |
| dis_req | input | 1 | Turn the line off |
| en_req | input | 1 | Turn the line back on |
| en_agent | input | AGENT_W | Agent that takes ownership if re-enable finds an event waiting |
| line_mask | output | 1 | 1 while the line is masked |
| run_req | output | 1 | Request to run the handlers |
| run_grant | input | 1 | Handler time granted |
| run_owner | output | AGENT_W | Index of the agent owning the line |
| pend_flag | output | 1 | Event pending |
| busy_flag | output | 1 | Line owned (in progress) |
| dis_flag | output | 1 | Line disabled |

## Verification
The assertions take for granted that `done_agent` and `en_agent` always carry an index below the agent count. They also assume `run_grant` only matters while a request is up. The owner-stability and foreign-done properties rest on these assumptions. The directed stimulus drives only legal agent indices. It raises `run_grant` only after seeing `run_req`, and it issues a done only after a grant, apart from the deliberately stray done strobes that exercise R9.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ASK   = 2'd1,
        S_SERVE = 2'd2
    } trk_state_e;
endpackage

// File: rtl/irq_trk_arb.sv
module irq_trk_arb #(
    parameter int N_AGENTS = 4,
    localparam int AGENT_W = (N_AGENTS < 2) ? 1 : $clog2(N_AGENTS)
) (
    input  logic [N_AGENTS-1:0] req,
    output logic                any,
    output logic [AGENT_W-1:0]  win_idx
);
    logic [N_AGENTS:0]   seen;
    logic [N_AGENTS-1:0] win_oh;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_pri
        assign win_oh[i]   = req[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req[i];
    end

    assign any = seen[N_AGENTS];

    always_comb begin
        win_idx = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            if (win_oh[k]) win_idx = win_idx | AGENT_W'(k);
        end
    end

    always_comb begin
        assert ($onehot0(win_oh));
    end
endmodule

// File: rtl/irq_trk_done_match.sv
module irq_trk_done_match #(
    parameter int N_AGENTS = 4,
    localparam int AGENT_W = (N_AGENTS < 2) ? 1 : $clog2(N_AGENTS)
) (
    input  logic               in_pass,
    input  logic               done_valid,
    input  logic [AGENT_W-1:0] done_agent,
    input  logic [AGENT_W-1:0] owner,
    output logic               done_ok
);
    assign done_ok = in_pass && done_valid && (done_agent == owner);
endmodule

// File: rtl/irq_trk_fsm.sv
module irq_trk_fsm
    import irq_trk_pkg::*;
#(
    parameter int N_AGENTS = 4,
    localparam int AGENT_W = (N_AGENTS < 2) ? 1 : $clog2(N_AGENTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arr_any,
    input  logic [AGENT_W-1:0] arr_win,
    input  logic               done_ok,
    input  logic               done_valid,
    input  logic [AGENT_W-1:0] done_agent,
    input  logic               dis_req,
    input  logic               en_req,
    input  logic [AGENT_W-1:0] en_agent,
    input  logic               run_grant,
    output logic               in_pass,
    output logic               line_mask,
    output logic               run_req,
    output logic [AGENT_W-1:0] owner,
    output logic               pend_flag,
    output logic               busy_flag,
    output logic               dis_flag
);
    trk_state_e         st_q, st_d;
    logic               pend_q, pend_d;
    logic               dis_q, dis_d;
    logic               mask_q, mask_d;
    logic [AGENT_W-1:0] own_q, own_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            pend_q <= 1'b0;
            dis_q  <= 1'b0;
            mask_q <= 1'b0;
            own_q  <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            dis_q  <= dis_d;
            mask_q <= mask_d;
            own_q  <= own_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        dis_d  = dis_q;
        mask_d = mask_q;
        own_d  = own_q;

        if (arr_any) begin
            pend_d = 1'b1;
            mask_d = 1'b1;
        end

        if (dis_req) begin
            dis_d  = 1'b1;
            mask_d = 1'b1;
        end else if (en_req) begin
            dis_d = 1'b0;
        end

        unique case (st_q)
            S_IDLE: begin
                if (arr_any && !dis_q) begin
                    st_d   = S_ASK;
                    pend_d = 1'b0;
                    own_d  = arr_win;
                end else if (en_req && !dis_req && dis_q) begin
                    if (pend_q || arr_any) begin
                        st_d   = S_ASK;
                        pend_d = 1'b0;
                        own_d  = en_agent;
                    end else begin
                        mask_d = 1'b0;
                    end
                end
            end
            S_ASK: begin
                if (run_grant) st_d = S_SERVE;
            end
            S_SERVE: begin
                if (done_ok) begin
                    if (pend_q || arr_any) begin
                        st_d   = S_ASK;
                        pend_d = 1'b0;
                    end else begin
                        st_d = S_IDLE;
                        if (!dis_d) mask_d = 1'b0;
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        in_pass   = (st_q == S_SERVE);
        run_req   = (st_q == S_ASK);
        busy_flag = (st_q != S_IDLE);
        line_mask = mask_q;
        owner     = own_q;
        pend_flag = pend_q;
        dis_flag  = dis_q;
    end

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !dis_q && arr_any) |=>
            (st_q == S_ASK && !pend_q && own_q == $past(arr_win)));

    p_mask_on_arrival_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_any |=> mask_q);

    p_owner_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |=> (st_q == S_IDLE || st_q == S_ASK && $past(st_q) == S_IDLE
                              || $stable(own_q)));

    p_foreign_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SERVE && done_valid && done_agent != own_q) |=> (st_q == S_SERVE));

    p_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SERVE && done_ok && pend_q) |=> (st_q == S_ASK && !pend_q));

    p_disabled_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |-> mask_q);

    p_dis_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_req && en_req) |=> dis_q);
endmodule

// File: rtl/irq_line_tracker.sv
module irq_line_tracker #(
    parameter int N_AGENTS = 4,
    localparam int AGENT_W = (N_AGENTS < 2) ? 1 : $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] arr_valid,
    output logic [N_AGENTS-1:0] ack_out,
    input  logic                done_valid,
    input  logic [AGENT_W-1:0]  done_agent,
    input  logic                dis_req,
    input  logic                en_req,
    input  logic [AGENT_W-1:0]  en_agent,
    output logic                line_mask,
    output logic                run_req,
    input  logic                run_grant,
    output logic [AGENT_W-1:0]  run_owner,
    output logic                pend_flag,
    output logic                busy_flag,
    output logic                dis_flag
);
    logic               arr_any;
    logic [AGENT_W-1:0] arr_win;
    logic               in_pass;
    logic               done_ok;
    logic [AGENT_W-1:0] owner;
    logic [N_AGENTS-1:0] ack_q;

    irq_trk_arb #(.N_AGENTS(N_AGENTS)) u_arb (
        .req     (arr_valid),
        .any     (arr_any),
        .win_idx (arr_win)
    );

    irq_trk_done_match #(.N_AGENTS(N_AGENTS)) u_done (
        .in_pass    (in_pass),
        .done_valid (done_valid),
        .done_agent (done_agent),
        .owner      (owner),
        .done_ok    (done_ok)
    );

    irq_trk_fsm #(.N_AGENTS(N_AGENTS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arr_any    (arr_any),
        .arr_win    (arr_win),
        .done_ok    (done_ok),
        .done_valid (done_valid),
        .done_agent (done_agent),
        .dis_req    (dis_req),
        .en_req     (en_req),
        .en_agent   (en_agent),
        .run_grant  (run_grant),
        .in_pass    (in_pass),
        .line_mask  (line_mask),
        .run_req    (run_req),
        .owner      (owner),
        .pend_flag  (pend_flag),
        .busy_flag  (busy_flag),
        .dis_flag   (dis_flag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= arr_valid;
    end

    assign ack_out   = ack_q;
    assign run_owner = owner;

    p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid != '0) |=> (ack_out == $past(arr_valid)));
endmodule

// File: tb/irq_line_tracker_test.sv
`timescale 1ns/1ps
module irq_line_tracker_test;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] arr_valid;
    logic [N-1:0] ack_out;
    logic         done_valid;
    logic [W-1:0] done_agent;
    logic         dis_req, en_req;
    logic [W-1:0] en_agent;
    logic         line_mask, run_req, run_grant;
    logic [W-1:0] run_owner;
    logic         pend_flag, busy_flag, dis_flag;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_line_tracker #(.N_AGENTS(N)) uut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .ack_out(ack_out),
        .done_valid(done_valid), .done_agent(done_agent), .dis_req(dis_req),
        .en_req(en_req), .en_agent(en_agent), .line_mask(line_mask),
        .run_req(run_req), .run_grant(run_grant), .run_owner(run_owner),
        .pend_flag(pend_flag), .busy_flag(busy_flag), .dis_flag(dis_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        arr_valid = '0; done_valid = 0; done_agent = '0;
        dis_req = 0; en_req = 0; en_agent = '0; run_grant = 0;
    endtask

    task automatic step_clear();
        tick();
        idle_inputs();
    endtask

    task automatic grant_pass();
        run_grant = 1; step_clear();
    endtask

    task automatic done_from(input int a);
        done_valid = 1; done_agent = W'(a); step_clear();
    endtask

    task automatic t_reset();
        chk("R1 mask", line_mask, 0);
        chk("R1 busy", busy_flag, 0);
        chk("R1 pend", pend_flag, 0);
        chk("R1 dis", dis_flag, 0);
        chk("R1 run_req", run_req, 0);
        chk("R1 ack", ack_out, 0);
    endtask

    task automatic t_single();
        arr_valid = 4'b0100; step_clear();
        chk("R2 ack", ack_out, 4'b0100);
        chk("R2 mask", line_mask, 1);
        chk("R3 busy", busy_flag, 1);
        chk("R3 pend", pend_flag, 0);
        chk("R3 owner", run_owner, 2);
        chk("R3 run_req", run_req, 1);
        tick();
        chk("R2 ack one cycle", ack_out, 0);
        done_from(2);
        chk("R9 done before grant ignored", run_req, 1);
        grant_pass();
        chk("R6 run_req drops", run_req, 0);
        chk("R6 busy", busy_flag, 1);
        done_from(1);
        chk("R9 foreign done busy", busy_flag, 1);
        chk("R9 foreign done mask", line_mask, 1);
        done_from(2);
        chk("R8 busy cleared", busy_flag, 0);
        chk("R8 unmask", line_mask, 0);
        chk("R8 run_req", run_req, 0);
    endtask

    task automatic t_simultaneous();
        arr_valid = 4'b1010; step_clear();
        chk("R4 owner lowest", run_owner, 1);
        chk("R4 pend", pend_flag, 0);
        chk("R2 ack both", ack_out, 4'b1010);
        grant_pass();
        done_from(1);
        chk("R4 single pass", busy_flag, 0);
    endtask

    task automatic t_busy_arrival();
        arr_valid = 4'b0001; step_clear();
        grant_pass();
        arr_valid = 4'b1000; step_clear();
        chk("R5 pend", pend_flag, 1);
        chk("R5 owner", run_owner, 0);
        done_from(0);
        chk("R7 pend cleared", pend_flag, 0);
        chk("R7 run_req again", run_req, 1);
        chk("R7 owner", run_owner, 0);
        grant_pass();
        done_from(0);
        chk("R8 end after loop", busy_flag, 0);
        chk("R8 unmask after loop", line_mask, 0);
    endtask

    task automatic t_disable_in_service();
        arr_valid = 4'b0010; step_clear();
        grant_pass();
        dis_req = 1; step_clear();
        chk("R10 dis set", dis_flag, 1);
        done_from(1);
        chk("R10 busy cleared", busy_flag, 0);
        chk("R10 stays masked", line_mask, 1);
        en_req = 1; step_clear();
        chk("R12 enable unmask", line_mask, 0);
        chk("R12 dis cleared", dis_flag, 0);
        chk("R12 no commit", busy_flag, 0);
    endtask

    task automatic t_disabled_arrival();
        dis_req = 1; step_clear();
        arr_valid = 4'b1000; step_clear();
        chk("R11 pend", pend_flag, 1);
        chk("R11 busy", busy_flag, 0);
        chk("R11 mask", line_mask, 1);
        en_req = 1; en_agent = 2'd2; step_clear();
        chk("R12 commit", busy_flag, 1);
        chk("R12 owner", run_owner, 2);
        chk("R12 pend", pend_flag, 0);
        chk("R12 run_req", run_req, 1);
        grant_pass();
        done_from(2);
        chk("R12 end unmask", line_mask, 0);
    endtask

    task automatic t_dis_en_same();
        dis_req = 1; en_req = 1; step_clear();
        chk("R13 disabled", dis_flag, 1);
        chk("R13 masked", line_mask, 1);
        en_req = 1; step_clear();
        chk("R13 later enable", dis_flag, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_single();
        t_simultaneous();
        t_busy_arrival();
        t_disable_in_service();
        t_disabled_arrival();
        t_dis_en_same();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule